// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Bank

A 32-bit general-purpose I/O peripheral behind a word-wide register bus. Software programs a direction register (1 = output) and moves output levels through two write-only strobe addresses, one that sets bits and one that clears them. Each strobe write is accepted or dropped as a whole. It is accepted only when its mask overlaps at least one output-configured bit. Once accepted, it applies to every bit in the mask. A dropped strobe write raises a one-cycle error pulse.

The pin-level register drives the output pins, and the direction register drives the pin output enables. When the level address is read, output-direction bits return the stored level. Input-direction bits return the input pins after a two-flop synchroniser. A spare 32-bit scratch register sits at its own address. Three edge-control addresses are decoded but hold no state. Nine interrupt lines are present and stay low. The bus handles whole aligned words only. Read data is registered one edge after the request.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the level, direction and scratch registers are zero, so pin_o, pin_oe_o, rdata_o and wr_err_o are all zero.
- R2: A write to offset 0x04 loads the direction register. A read of 0x04 returns it. pin_oe_o equals the direction register bit for bit.
- R3: A write to offset 0x08 whose data overlaps the direction register in at least one bit ORs every data bit into the level register. pin_o equals the level register.
- R4: A write to offset 0x0C whose data overlaps the direction register in at least one bit clears every data bit in the level register.
- R5: A write to 0x08 or 0x0C with no overlap leaves the level register unchanged. It drives wr_err_o high for exactly the one cycle after the write edge.
- R6: Writes to offsets 0x10, 0x14 and 0x18 change no state. Reads from them return zero.
- R7: Offset 0x20 is a 32-bit scratch register that reads back what was written and affects no other register or pin.
- R8: An access whose address has bits [1:0] nonzero, or whose offset is not listed, reads zero and writes nothing.
- R9: A read of offset 0x00 returns the level bit for each output-direction bit. For each input-direction bit it returns pin_i as synchronised through two flops.
- R10: irq_o (9 bits) stays zero at all times.
- R11: rdata_o takes the addressed value on the clock edge that samples re_i high. It holds its value while re_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address of the access |
| we_i | input | 1 | Write request |
| re_i | input | 1 | Read request |
| wdata_i | input | 32 | Write data or set/clear mask |
| rdata_o | output | 32 | Registered read data |
| wr_err_o | output | 1 | One-cycle pulse on a dropped set/clear write |
| pin_i | input | 32 | Input pin levels (asynchronous) |
| pin_o | output | 32 | Output pin levels |
| pin_oe_o | output | 32 | Output enables, 1 = driven |
| irq_o | output | 9 | Interrupt lines, held low |

## Verification
The set and clear strobes are tried with masks that span output and input bits together, with masks touching only input bits, and with masks touching no bits at all. These cases separate the whole-write acceptance rule from a per-bit rule. The level readback is tried with a checkerboard on the input pins under a mixed direction. This shows that output bits come from the register and input bits come from the synchroniser. Misaligned and unmapped addresses that alias a live register in their upper bits are written and read back. This shows that decoding needs the low address bits to be zero.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 6;
  parameter int IRQ_N  = 9;
  parameter int SYNC_STAGES = 2;

  parameter logic [7:0] OFF_LEVEL = 8'h00;
  parameter logic [7:0] OFF_DIR   = 8'h04;
  parameter logic [7:0] OFF_SET   = 8'h08;
  parameter logic [7:0] OFF_CLR   = 8'h0C;
  parameter logic [7:0] OFF_RISE  = 8'h10;
  parameter logic [7:0] OFF_FALL  = 8'h14;
  parameter logic [7:0] OFF_EDGE  = 8'h18;
  parameter logic [7:0] OFF_AUX   = 8'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_DIR,
    SEL_SET,
    SEL_CLR,
    SEL_EDGE,
    SEL_AUX
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] aux_o,
  output logic         wr_err_o
);
  logic [W-1:0] level_q, dir_q, aux_q;
  logic         err_q;
  logic         overlap, set_ok, clr_ok, rejected;

  assign overlap  = |(dir_q & wdata_i);
  assign set_ok   = we_i && (sel_i == SEL_SET) && overlap;
  assign clr_ok   = we_i && (sel_i == SEL_CLR) && overlap;
  // whole-write rejection: mask touches no output bit
  assign rejected = we_i && (sel_i == SEL_SET || sel_i == SEL_CLR) && !overlap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
    end else if (set_ok) begin
      level_q <= level_q | wdata_i;
    end else if (clr_ok) begin
      level_q <= level_q & ~wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          dir_q <= '0;
    else if (we_i && sel_i == SEL_DIR)    dir_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          aux_q <= '0;
    else if (we_i && sel_i == SEL_AUX)    aux_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= rejected;
  end

  assign level_o  = level_q;
  assign dir_o    = dir_q;
  assign aux_o    = aux_q;
  assign wr_err_o = err_q;

  AST_SET_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ok |=> ((level_q & $past(wdata_i)) == $past(wdata_i)));  // R3
  AST_CLR_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ok |=> ((level_q & $past(wdata_i)) == '0));  // R4
  AST_LEVEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_ok || clr_ok) |=> $stable(level_q));  // R5
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejected |=> wr_err_o);  // R5
  AST_AUX_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i == SEL_AUX) |=> $stable(aux_q));  // R7
  AST_DIR_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i == SEL_DIR) |=> $stable(dir_q));  // R2
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         re_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] aux_i,
  input  logic [W-1:0] pin_sync_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] rd_mux, rdata_q;

  always_comb begin
    unique case (sel_i)
      SEL_LEVEL: rd_mux = (level_i & dir_i) | (pin_sync_i & ~dir_i);
      SEL_DIR:   rd_mux = dir_i;
      SEL_AUX:   rd_mux = aux_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));  // R11
  AST_ZERO_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (sel_i == SEL_EDGE || sel_i == SEL_NONE)) |=> (rdata_o == '0));  // R6
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int AW     = ADDR_W,
  parameter int NIRQ   = IRQ_N,
  parameter int NSYNC  = SYNC_STAGES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    rdata_o,
  output logic            wr_err_o,
  input  logic [W-1:0]    pin_i,
  output logic [W-1:0]    pin_o,
  output logic [W-1:0]    pin_oe_o,
  output logic [NIRQ-1:0] irq_o
);
  reg_sel_e     sel;
  logic [W-1:0] level, dir, aux, pin_sync;

  // word accesses only: low address bits must be zero
  always_comb begin
    sel = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if      (addr_i == AW'(OFF_LEVEL)) sel = SEL_LEVEL;
      else if (addr_i == AW'(OFF_DIR))   sel = SEL_DIR;
      else if (addr_i == AW'(OFF_SET))   sel = SEL_SET;
      else if (addr_i == AW'(OFF_CLR))   sel = SEL_CLR;
      else if (addr_i == AW'(OFF_RISE) || addr_i == AW'(OFF_FALL) ||
               addr_i == AW'(OFF_EDGE))  sel = SEL_EDGE;
      else if (addr_i == AW'(OFF_AUX))   sel = SEL_AUX;
    end
  end

  gpio_sync #(.W(W), .STAGES(NSYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .level_o  (level),
    .dir_o    (dir),
    .aux_o    (aux),
    .wr_err_o (wr_err_o)
  );

  gpio_rd_path #(.W(W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .re_i       (re_i),
    .sel_i      (sel),
    .level_i    (level),
    .dir_i      (dir),
    .aux_i      (aux),
    .pin_sync_i (pin_sync),
    .rdata_o    (rdata_o)
  );

  assign pin_o    = level;
  assign pin_oe_o = dir;
  assign irq_o    = '0;

  AST_PIN_MATCHES_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == SEL_LEVEL && !we_i && pin_oe_o == '1) |=> (rdata_o == $past(pin_o)));  // R9
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wr_err_o;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o;
  logic [31:0] pin_oe_o;
  logic [8:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  gpio_bank dut_i (.*);

  typedef struct packed {
    logic        rd;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] pins;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h04, 32'h0000_00FF, 32'h0,         32'h0,         1'b0}, // R2 dir
    '{1'b1, 6'h04, 32'h0,         32'h0,         32'h0000_00FF, 1'b0}, // R2
    '{1'b0, 6'h08, 32'h0000_0F0F, 32'h0,         32'h0,         1'b0}, // R3 mixed mask
    '{1'b1, 6'h00, 32'h0,         32'h0,         32'h0000_000F, 1'b0}, // R9
    '{1'b0, 6'h08, 32'h0001_0000, 32'h0,         32'h0,         1'b1}, // R5 no overlap
    '{1'b1, 6'h00, 32'h0,         32'h0,         32'h0000_000F, 1'b0}, // R5
    '{1'b1, 6'h00, 32'h0,         32'hA5A5_A5A5, 32'hA5A5_A50F, 1'b0}, // R9 pins
    '{1'b0, 6'h0C, 32'h0000_0103, 32'h0,         32'h0,         1'b0}, // R4
    '{1'b1, 6'h00, 32'h0,         32'h0,         32'h0000_000C, 1'b0}, // R4
    '{1'b0, 6'h0C, 32'h0000_0E00, 32'h0,         32'h0,         1'b1}, // R5 clr drop
    '{1'b0, 6'h04, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b0}, // R2
    '{1'b1, 6'h00, 32'h0,         32'hFFFF_0000, 32'h0000_0E0C, 1'b0}, // R4/R5 kept
    '{1'b0, 6'h08, 32'h0,         32'h0,         32'h0,         1'b1}, // R5 empty mask
    '{1'b0, 6'h10, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b0}, // R6
    '{1'b0, 6'h14, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b0}, // R6
    '{1'b0, 6'h18, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b0}, // R6
    '{1'b1, 6'h10, 32'h0,         32'h0,         32'h0,         1'b0}, // R6
    '{1'b1, 6'h18, 32'h0,         32'h0,         32'h0,         1'b0}, // R6
    '{1'b0, 6'h20, 32'hDEAD_BEEF, 32'h0,         32'h0,         1'b0}, // R7
    '{1'b1, 6'h20, 32'h0,         32'h0,         32'hDEAD_BEEF, 1'b0}, // R7
    '{1'b1, 6'h00, 32'h0,         32'h0,         32'h0000_0E0C, 1'b0}, // R7 no side effect
    '{1'b0, 6'h24, 32'h0000_1234, 32'h0,         32'h0,         1'b0}, // R8
    '{1'b1, 6'h24, 32'h0,         32'h0,         32'h0,         1'b0}, // R8
    '{1'b0, 6'h22, 32'h0000_0055, 32'h0,         32'h0,         1'b0}, // R8 misaligned
    '{1'b1, 6'h20, 32'h0,         32'h0,         32'hDEAD_BEEF, 1'b0}, // R8
    '{1'b0, 6'h05, 32'h0,         32'h0,         32'h0,         1'b0}, // R8 misaligned dir
    '{1'b1, 6'h04, 32'h0,         32'h0,         32'hFFFF_FFFF, 1'b0}  // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic rd, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = !rd; re_i = rd; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 pin_o", pin_o, 32'h0);
    check("R1 pin_oe_o", pin_oe_o, 32'h0);
    check("R1 rdata_o", rdata_o, 32'h0);
    check("R1 wr_err_o", {31'h0, wr_err_o}, 32'h0);
    check("R10 irq_o", {23'h0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      pin_i = VEC[i].pins;
      repeat (3) @(negedge clk_i);
      bus(VEC[i].rd, VEC[i].addr, VEC[i].data);
      if (VEC[i].rd) check($sformatf("R9/R11 vec %0d rdata", i), rdata_o, VEC[i].exp);
      check($sformatf("R5 vec %0d err", i), {31'h0, wr_err_o}, {31'h0, VEC[i].err});
    end

    // R2 and R3: pins follow the registers
    check("R3 pin_o", pin_o, 32'h0000_0E0C);
    check("R2 pin_oe_o", pin_oe_o, 32'hFFFF_FFFF);

    // R5: error is exactly one cycle wide
    bus(1'b0, 6'h04, 32'h0000_0001);
    bus(1'b0, 6'h08, 32'h0000_0100);
    check("R5 err high", {31'h0, wr_err_o}, 32'h1);
    @(negedge clk_i);
    check("R5 err low", {31'h0, wr_err_o}, 32'h0);
    check("R5 pin_o kept", pin_o, 32'h0000_0E0C);

    // R3: accepted set applies to input-direction bits as well
    bus(1'b0, 6'h08, 32'h8000_0001);
    check("R3 all mask bits", pin_o, 32'h8000_0E0D);

    // R11: rdata_o holds when re_i is low
    bus(1'b1, 6'h20, 32'h0);
    bus(1'b0, 6'h20, 32'h1111_2222);
    repeat (2) @(negedge clk_i);
    check("R11 hold", rdata_o, 32'hDEAD_BEEF);

    // R10 after activity
    check("R10 irq_o", {23'h0, irq_o}, 32'h0);

    // R1: reset mid-run clears state
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 pin_o after reset", pin_o, 32'h0);
    check("R1 pin_oe_o after reset", pin_oe_o, 32'h0);
    bus(1'b1, 6'h20, 32'h0);
    check("R1 aux after reset", rdata_o, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule